// File: doc/BRIEF.md
# Coprocessor Register Transfer Unit

This block is the register side of a coprocessor attached to a host core. It keeps sixteen 64-bit registers, each addressed as two 32-bit halves, and carries out the three kinds of transfer the host can issue against them: a move of a host word into one half of a register, a move of one half back to the host, and a load of memory words arriving one 32-bit word per cycle. Register indices and a three-bit sub-opcode are taken from fixed fields of the 32-bit instruction word presented with each operation.

A load with the double-word bit set spans two data cycles. The half that takes the first word is picked by the big-endian input, and the second word fills the other half. The block answers every operation in the same cycle, with either a continue indication (more words expected) or a done indication. A single-word load writes only the upper half in the floating group, and writes the whole register, sign-extended, in the integer group. A sub-opcode the block does not know raises a sticky illegal flag and changes no register.

Top module: `cpx_xfer_unit`

## Requirements
- R1: After reset every register half reads 0, `illegal_o` is 0 and the next double-word load starts with its first word.
- R2: A host-to-coprocessor move (`op_kind_i`=0) writes `wdata_i` into the register named by instruction bits 19:16 on the clock edge: sub-opcode (bits 7:5) 0 writes the lower half, 1 writes the upper half, and in the floating group (`int_grp_i`=0) 2 also writes the upper half. The other half is left unchanged.
- R3: A coprocessor-to-host move (`op_kind_i`=1) drives `rdata_o` combinationally in the same cycle with the lower half (sub-opcode 0) or the upper half (sub-opcode 1, and also 2 in the floating group) of the register named by bits 19:16. `rdata_o` is 0 in every other cycle.
- R4: A load (`op_kind_i`=2) in a data cycle with bit 22 set targets the register named by bits 15:12. Its first word goes to the upper half when `big_endian_i` is 1 and to the lower half otherwise. Its second word goes to the other half.
- R5: For each valid operation exactly one of `inc_o` and `done_o` is 1. `inc_o` is 1 only on the first word of a double-word load.
- R6: A load presented with `data_phase_i`=0 writes nothing, answers done, and restarts the double-word sequence so that the next data word is treated as a first word.
- R7: A single-word load (bit 22 clear) in the floating group writes `wdata_i` to the upper half only.
- R8: A single-word load in the integer group (`int_grp_i`=1) writes `wdata_i` to the lower half and fills the upper half with copies of `wdata_i` bit 31.
- R9: Operation kind 3, a move sub-opcode above 2 in the floating group, and a move sub-opcode above 1 in the integer group are illegal. They set `illegal_o` from the next cycle until reset, answer done and leave all registers unchanged.
- R10: While `op_valid_i` is 0 no register changes and `inc_o`, `done_o` and `rdata_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | An operation is presented this cycle |
| op_kind_i | input | 2 | 0 move to coprocessor, 1 move to host, 2 load, 3 reserved |
| int_grp_i | input | 1 | 0 floating group, 1 integer group |
| instr_i | input | 32 | Instruction word carrying indices, sub-opcode and double-word bit |
| data_phase_i | input | 1 | Load cycle carries a data word (0: non-data phase) |
| big_endian_i | input | 1 | Word order of double-word loads |
| wdata_i | input | 32 | Host word or memory word |
| rdata_o | output | 32 | Half read by a move to host |
| inc_o | output | 1 | Continue: another load word is expected |
| done_o | output | 1 | Operation complete |
| illegal_o | output | 1 | Sticky illegal-operation flag |

## Verification
The handshake and the read data are combinational, so they are due in the same cycle as the operation: the bench drives inputs just after a falling edge and samples `inc_o`, `done_o` and `rdata_o` one nanosecond later, before the rising edge. Register writes and the illegal flag take effect at the rising edge, so their effect is checked from the next operation on, through a later move to host and through `illegal_o` sampled before that next operation is driven. A bench model of the sixteen registers, the word position and the flag is updated after each rising edge, and a full read-back sweep closes the run.

// File: rtl/cpx_pkg.sv
package cpx_pkg;
  localparam int unsigned INSTR_W   = 32;
  localparam int unsigned IDX_W     = 4;
  localparam int unsigned SUB_W     = 3;
  localparam int unsigned SRC_LSB   = 16;
  localparam int unsigned DST_LSB   = 12;
  localparam int unsigned SUB_LSB   = 5;
  localparam int unsigned DWORD_BIT = 22;

  localparam logic [SUB_W-1:0] FLT_SUB_MAX = 3'd2;
  localparam logic [SUB_W-1:0] INT_SUB_MAX = 3'd1;

  typedef enum logic [1:0] {
    K_TO_CP   = 2'd0,
    K_TO_HOST = 2'd1,
    K_LOAD    = 2'd2,
    K_RSVD    = 2'd3
  } op_kind_e;

  typedef struct packed {
    logic wr_lo;
    logic wr_hi;
    logic sext;
    logic rd_en;
    logic rd_hi;
    logic illegal;
    logic inc;
    logic done;
    logic cnt_adv;
    logic cnt_clr;
  } xfer_ctl_t;
endpackage

// File: rtl/cpx_decode.sv
module cpx_decode
  import cpx_pkg::*;
(
  input  logic               valid_i,
  input  op_kind_e           kind_i,
  input  logic               int_grp_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               data_phase_i,
  input  logic               big_endian_i,
  input  logic               second_i,
  output xfer_ctl_t          ctl_o,
  output logic [IDX_W-1:0]   wr_idx_o,
  output logic [IDX_W-1:0]   rd_idx_o
);
  logic [IDX_W-1:0] src_idx, dst_idx;
  logic [SUB_W-1:0] sub_op;
  logic             dword, sub_ok;
  logic             unused_instr_bits;

  assign src_idx = instr_i[SRC_LSB +: IDX_W];
  assign dst_idx = instr_i[DST_LSB +: IDX_W];
  assign sub_op  = instr_i[SUB_LSB +: SUB_W];
  assign dword   = instr_i[DWORD_BIT];
  assign sub_ok  = int_grp_i ? (sub_op <= INT_SUB_MAX) : (sub_op <= FLT_SUB_MAX);

  assign unused_instr_bits = ^{instr_i[INSTR_W-1:DWORD_BIT+1],
                               instr_i[DWORD_BIT-1:SRC_LSB+IDX_W],
                               instr_i[DST_LSB-1:SUB_LSB+SUB_W],
                               instr_i[SUB_LSB-1:0]};

  always_comb begin
    ctl_o    = '0;
    wr_idx_o = src_idx;
    rd_idx_o = src_idx;
    if (valid_i) begin
      unique case (kind_i)
        K_TO_CP: begin
          ctl_o.done = 1'b1;
          if (sub_ok) begin
            ctl_o.wr_lo = (sub_op == '0);
            ctl_o.wr_hi = (sub_op != '0);
          end else begin
            ctl_o.illegal = 1'b1;
          end
        end
        K_TO_HOST: begin
          ctl_o.done = 1'b1;
          if (sub_ok) begin
            ctl_o.rd_en = 1'b1;
            ctl_o.rd_hi = (sub_op != '0);
          end else begin
            ctl_o.illegal = 1'b1;
          end
        end
        K_LOAD: begin
          wr_idx_o = dst_idx;
          if (!data_phase_i) begin
            ctl_o.cnt_clr = 1'b1;
            ctl_o.done    = 1'b1;
          end else if (dword) begin
            if (!second_i) begin
              // first word: endianness picks the half
              ctl_o.wr_hi   = big_endian_i;
              ctl_o.wr_lo   = !big_endian_i;
              ctl_o.cnt_adv = 1'b1;
              ctl_o.inc     = 1'b1;
            end else begin
              ctl_o.wr_hi   = !big_endian_i;
              ctl_o.wr_lo   = big_endian_i;
              ctl_o.cnt_clr = 1'b1;
              ctl_o.done    = 1'b1;
            end
          end else if (int_grp_i) begin
            ctl_o.wr_lo = 1'b1;
            ctl_o.wr_hi = 1'b1;
            ctl_o.sext  = 1'b1;
            ctl_o.done  = 1'b1;
          end else begin
            ctl_o.wr_hi = 1'b1;
            ctl_o.done  = 1'b1;
          end
        end
        default: begin
          ctl_o.illegal = 1'b1;
          ctl_o.done    = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/cpx_load_seq.sv
module cpx_load_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic clr_i,
  output logic second_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    second_o <= 1'b0;
    else if (clr_i) second_o <= 1'b0;
    else if (adv_i) second_o <= 1'b1;
  end

  // R4: a first word always moves the sequence to its second word
  a_r4_adv_to_second: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> second_o);
  // R4: no advance is requested while already waiting for the second word
  a_r4_no_double_adv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> !second_o);
  // R6: a restart returns the sequence to its first word
  a_r6_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !second_o);
endmodule

// File: rtl/cpx_regfile.sv
module cpx_regfile #(
  parameter int unsigned NREGS  = 16,
  parameter int unsigned HALF_W = 32,
  localparam int unsigned IDX_W = $clog2(NREGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_lo_i,
  input  logic              we_hi_i,
  input  logic              sext_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [HALF_W-1:0] wdata_i,
  input  logic              rd_en_i,
  input  logic              rd_hi_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [HALF_W-1:0] rd_data_o
);
  logic [NREGS-1:0][HALF_W-1:0] lo_q, hi_q;
  logic [HALF_W-1:0]            hi_wdata;

  assign hi_wdata = sext_i ? {HALF_W{wdata_i[HALF_W-1]}} : wdata_i;

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q[g] <= '0;
        hi_q[g] <= '0;
      end else begin
        if (we_lo_i && (wr_idx_i == IDX_W'(g))) lo_q[g] <= wdata_i;
        if (we_hi_i && (wr_idx_i == IDX_W'(g))) hi_q[g] <= hi_wdata;
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_en_i) rd_data_o = rd_hi_i ? hi_q[rd_idx_i] : lo_q[rd_idx_i];
  end

  // R10: storage holds when no half is written
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_lo_i && !we_hi_i) |=> ($stable(lo_q) && $stable(hi_q)));
  // R2: a lower-half write leaves every upper half alone
  a_r2_upper_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_lo_i && !we_hi_i) |=> $stable(hi_q));
  // R7: an upper-half write leaves every lower half alone
  a_r7_lower_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_hi_i && !we_lo_i) |=> $stable(lo_q));
  // R8: a sign-extending write leaves the upper half a copy of the lower sign
  a_r8_sext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_lo_i && we_hi_i && sext_i) |=>
      (hi_q[$past(wr_idx_i)] == {HALF_W{lo_q[$past(wr_idx_i)][HALF_W-1]}}));
endmodule

// File: rtl/cpx_xfer_unit.sv
module cpx_xfer_unit
  import cpx_pkg::*;
#(
  parameter int unsigned HALF_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               op_valid_i,
  input  logic [1:0]         op_kind_i,
  input  logic               int_grp_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               data_phase_i,
  input  logic               big_endian_i,
  input  logic [HALF_W-1:0]  wdata_i,
  output logic [HALF_W-1:0]  rdata_o,
  output logic               inc_o,
  output logic               done_o,
  output logic               illegal_o
);
  localparam int unsigned NREGS = 1 << IDX_W;

  xfer_ctl_t        ctl;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic             second;

  cpx_decode u_decode (
    .valid_i      (op_valid_i),
    .kind_i       (op_kind_e'(op_kind_i)),
    .int_grp_i    (int_grp_i),
    .instr_i      (instr_i),
    .data_phase_i (data_phase_i),
    .big_endian_i (big_endian_i),
    .second_i     (second),
    .ctl_o        (ctl),
    .wr_idx_o     (wr_idx),
    .rd_idx_o     (rd_idx)
  );

  cpx_load_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (ctl.cnt_adv),
    .clr_i    (ctl.cnt_clr),
    .second_o (second)
  );

  cpx_regfile #(.NREGS(NREGS), .HALF_W(HALF_W)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_lo_i   (ctl.wr_lo),
    .we_hi_i   (ctl.wr_hi),
    .sext_i    (ctl.sext),
    .wr_idx_i  (wr_idx),
    .wdata_i   (wdata_i),
    .rd_en_i   (ctl.rd_en),
    .rd_hi_i   (ctl.rd_hi),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          illegal_o <= 1'b0;
    else if (ctl.illegal) illegal_o <= 1'b1;
  end

  assign inc_o  = ctl.inc;
  assign done_o = ctl.done;

  // R5: one response per valid operation
  a_r5_one_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i |-> (inc_o ^ done_o));
  // R5: a continue is always followed by a sequence waiting for its second word
  a_r5_inc_then_second: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_o |=> second);
  // R9: the illegal flag is sticky
  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> illegal_o);
  // R10: idle cycles are silent
  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |-> (!inc_o && !done_o && (rdata_o == '0)));
endmodule

// File: tb/tb_cpx_xfer_unit.sv
`timescale 1ns/1ps
module tb_cpx_xfer_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        op_valid_i = 1'b0;
  logic [1:0]  op_kind_i = '0;
  logic        int_grp_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic        data_phase_i = 1'b0;
  logic        big_endian_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        inc_o, done_o, illegal_o;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;

  logic [31:0] m_lo [16];
  logic [31:0] m_hi [16];
  logic        m_second = 1'b0;
  logic        m_ill = 1'b0;

  always #2.5 clk = ~clk;

  cpx_xfer_unit dut (
    .clk_i(clk), .rst_ni(rst_ni), .op_valid_i(op_valid_i), .op_kind_i(op_kind_i),
    .int_grp_i(int_grp_i), .instr_i(instr_i), .data_phase_i(data_phase_i),
    .big_endian_i(big_endian_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .inc_o(inc_o), .done_o(done_o), .illegal_o(illegal_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic sub_legal(input logic [1:0] k, input logic g, input logic [2:0] s);
    if (k == 2'd3) return 1'b0;
    if (k == 2'd2) return 1'b1;
    return g ? (s <= 3'd1) : (s <= 3'd2);
  endfunction

  // one operation: drive after falling edge, check combinational outputs, update model after rising edge
  task automatic op(input logic vld, input logic [1:0] k, input logic g, input logic [2:0] s,
                    input logic [3:0] src, input logic [3:0] dst, input logic dw,
                    input logic dp, input logic be, input logic [31:0] wd, input string req);
    logic [31:0] ins;
    logic [31:0] e_rd;
    logic        e_inc, e_done, legal;
    @(negedge clk);
    check("R9 flag", {31'b0, illegal_o}, {31'b0, m_ill});
    ins = $urandom;
    ins[22] = dw; ins[19:16] = src; ins[15:12] = dst; ins[7:5] = s;
    op_valid_i = vld; op_kind_i = k; int_grp_i = g; instr_i = ins;
    data_phase_i = dp; big_endian_i = be; wdata_i = wd;
    e_rd = '0; e_inc = 1'b0; e_done = 1'b0;
    legal = sub_legal(k, g, s);
    if (vld) begin
      e_done = 1'b1;
      if (legal && k == 2'd1) e_rd = (s == 3'd0) ? m_lo[src] : m_hi[src];
      if (k == 2'd2 && dp && dw && !m_second) begin e_inc = 1'b1; e_done = 1'b0; end
    end
    #1;
    check({req, " rdata"}, rdata_o, e_rd);
    check({req, " inc"}, {31'b0, inc_o}, {31'b0, e_inc});
    check({req, " done"}, {31'b0, done_o}, {31'b0, e_done});
    @(posedge clk);
    if (vld) begin
      if (!legal) m_ill = 1'b1;
      else if (k == 2'd0) begin
        if (s == 3'd0) m_lo[src] = wd; else m_hi[src] = wd;
      end else if (k == 2'd2) begin
        if (!dp) m_second = 1'b0;
        else if (dw) begin
          if (!m_second) begin
            if (be) m_hi[dst] = wd; else m_lo[dst] = wd;
            m_second = 1'b1;
          end else begin
            if (be) m_lo[dst] = wd; else m_hi[dst] = wd;
            m_second = 1'b0;
          end
        end else if (g) begin
          m_lo[dst] = wd; m_hi[dst] = {32{wd[31]}};
        end else m_hi[dst] = wd;
      end
    end
  endtask

  task automatic rd(input logic [3:0] r, input logic hi, input string req);
    op(1'b1, 2'd1, 1'b0, hi ? 3'd1 : 3'd0, r, 4'd0, 1'b0, 1'b0, 1'b0, '0, req);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 16; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;

    // R1: reset state
    rd(4'd7, 1'b0, "R1 lo"); rd(4'd7, 1'b1, "R1 hi");

    // R2 / R3: moves, both halves, sub-opcode 2 in floating group
    op(1, 2'd0, 0, 3'd0, 4'd3, 4'd0, 0, 0, 0, 32'hA5A5_0001, "R2 lo");
    op(1, 2'd0, 1, 3'd1, 4'd3, 4'd0, 0, 0, 0, 32'h1234_5678, "R2 hi");
    rd(4'd3, 1'b0, "R2 lo kept"); rd(4'd3, 1'b1, "R3 hi");
    op(1, 2'd0, 0, 3'd2, 4'd3, 4'd0, 0, 0, 0, 32'hDEAD_BEEF, "R2 sub2");
    op(1, 2'd1, 0, 3'd2, 4'd3, 4'd0, 0, 0, 0, '0, "R3 sub2");

    // R10: idle cycle with write-like inputs changes nothing
    op(0, 2'd0, 0, 3'd0, 4'd3, 4'd0, 0, 0, 0, 32'hFFFF_FFFF, "R10 idle");
    rd(4'd3, 1'b0, "R10 lo");

    // R4 / R5: double loads in both orders
    op(1, 2'd2, 0, 3'd0, 4'd0, 4'd9, 1, 1, 0, 32'h1111_1111, "R4 le w0");
    op(1, 2'd2, 0, 3'd0, 4'd0, 4'd9, 1, 1, 0, 32'h2222_2222, "R5 le w1");
    rd(4'd9, 1'b0, "R4 le lo"); rd(4'd9, 1'b1, "R4 le hi");
    op(1, 2'd2, 1, 3'd0, 4'd0, 4'd10, 1, 1, 1, 32'h3333_3333, "R4 be w0");
    op(1, 2'd2, 1, 3'd0, 4'd0, 4'd10, 1, 1, 1, 32'h4444_4444, "R5 be w1");
    rd(4'd10, 1'b0, "R4 be lo"); rd(4'd10, 1'b1, "R4 be hi");

    // R6: non-data phase mid-sequence restarts it
    op(1, 2'd2, 0, 3'd0, 4'd0, 4'd11, 1, 1, 0, 32'h5555_5555, "R6 w0");
    op(1, 2'd2, 0, 3'd0, 4'd0, 4'd11, 1, 0, 0, 32'h6666_6666, "R6 nodata");
    op(1, 2'd2, 0, 3'd0, 4'd0, 4'd11, 1, 1, 0, 32'h7777_7777, "R6 restart w0");
    op(1, 2'd2, 0, 3'd0, 4'd0, 4'd11, 1, 1, 0, 32'h8888_8888, "R6 w1");
    rd(4'd11, 1'b0, "R6 lo"); rd(4'd11, 1'b1, "R6 hi");

    // R7 / R8: single-word loads
    op(1, 2'd2, 0, 3'd0, 4'd0, 4'd12, 0, 1, 0, 32'h9999_0000, "R7 flt");
    rd(4'd12, 1'b0, "R7 lo kept"); rd(4'd12, 1'b1, "R7 hi");
    op(1, 2'd2, 1, 3'd0, 4'd0, 4'd13, 0, 1, 0, 32'h8000_0005, "R8 neg");
    rd(4'd13, 1'b0, "R8 lo"); rd(4'd13, 1'b1, "R8 hi neg");
    op(1, 2'd2, 1, 3'd0, 4'd0, 4'd13, 0, 1, 0, 32'h7FFF_FFFF, "R8 pos");
    rd(4'd13, 1'b1, "R8 hi pos");

    // R9: illegal integer sub-opcode 2, then reserved kind
    op(1, 2'd0, 1, 3'd2, 4'd3, 4'd0, 0, 0, 0, 32'h0BAD_0BAD, "R9 int sub2");
    rd(4'd3, 1'b1, "R9 unchanged");
    op(1, 2'd3, 0, 3'd0, 4'd3, 4'd3, 0, 1, 0, 32'h0BAD_0BAD, "R9 kind3");
    rd(4'd3, 1'b0, "R9 unchanged lo");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] k;
      logic [2:0] s;
      int unsigned p;
      p = $urandom_range(0, 99);
      k = (p < 30) ? 2'd0 : (p < 60) ? 2'd1 : (p < 97) ? 2'd2 : 2'd3;
      s = ($urandom_range(0, 9) == 0) ? 3'($urandom_range(3, 7)) : 3'($urandom_range(0, 2));
      op(1'($urandom_range(0, 9) != 0), k, 1'($urandom), s, 4'($urandom), 4'($urandom),
         1'($urandom_range(0, 2) != 0), 1'($urandom_range(0, 7) != 0), 1'($urandom),
         $urandom, "R2-mix R3 R4 R5 R6 R7 R8 R9 R10");
    end

    // full read-back sweep
    for (int r = 0; r < 16; r++) begin
      rd(4'(r), 1'b0, "R2 sweep lo");
      rd(4'(r), 1'b1, "R4 sweep hi");
    end
    summary();
  end
endmodule